// File: doc/BRIEF.md
# Predicated Quadword Load-and-Broadcast Unit

This unit executes one vector instruction that fetches a single 128-bit quadword from memory and copies it into every 128-bit slice of a destination vector register. It accepts an instruction word and decodes its fields. It gives the register file the indices of the base, offset and predicate registers it needs, and takes their values back in the same cycle. From these it forms the effective address. The address uses either a signed 4-bit immediate scaled by 16 or an offset register scaled by the element size.

The governing predicate decides which elements are read. Byte enables for the single 16-byte read are cleared for disabled elements. Once the response returns, those elements are forced to zero. The masked quadword is then broadcast across the active segments of a vector whose maximum width is a parameter. A run-time segment count selects how many segments are active. A base register index of 31 names the stack pointer, which must be 16-byte aligned. A misaligned stack pointer raises a fault and no memory traffic is issued.

Top module: `qld_bcast_unit`

## Requirements
- R1: When instruction bits 22:21 are not zero, the unit raises `undef_pulse` for one cycle, in the cycle after acceptance, and issues no memory request. This check has priority over the alignment check.
- R2: The unit decodes the following fields. The destination register is bits 4:0 and the base register is bits 9:5. The predicate register is bits 12:10. The offset register is bits 20:16. The element size is bits 24:23, where 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes.
- R3: When `issue_imm_form` is 1, the address is base + 16 × sext(bits 19:16).
- R4: When `issue_imm_form` is 0, the address is base + offset × element size in bytes.
- R5: Element i uses the predicate bit at position i × element size. Byte b of `mem_req_be` is set only when its element's predicate bit is set.
- R6: In the returned quadword, bytes whose enable was clear are written as zero. All other bytes carry the memory data.
- R7: The masked quadword occupies segments 0 to `seg_count-1` of `wb_data`. Higher segments are zero.
- R8: When the base index is 31 and `base_value[3:0]` is not zero, the unit raises `fault_pulse` for one cycle, in the cycle after acceptance, and issues no request.
- R9: `mem_req_valid`, `mem_req_addr` and `mem_req_be` hold steady until `mem_req_ready` is seen. `wb_valid` rises in the cycle after `mem_rsp_valid`.
- R10: After reset the unit is idle, with `issue_ready` at 1 and no request or write-back. It accepts a new instruction only when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Unit idle and able to accept |
| issue_insn | input | 32 | Instruction word |
| issue_imm_form | input | 1 | 1 = immediate offset form, 0 = register offset form |
| base_sel | output | 5 | Base register index for the register file |
| offset_sel | output | 5 | Offset register index for the register file |
| pred_sel | output | 3 | Predicate register index for the register file |
| base_value | input | AW | Base register value (the stack pointer when index is 31) |
| offset_value | input | AW | Offset register value |
| pred_value | input | 16 | Low 16 bits of the governing predicate |
| seg_count | input | SEG_W | Number of active 128-bit segments |
| undef_pulse | output | 1 | Undefined instruction indication |
| fault_pulse | output | 1 | Stack-pointer alignment fault |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | AW | Read address |
| mem_req_be | output | 16 | Per-byte read enables |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 128 | Read data |
| wb_valid | output | 1 | Destination write strobe |
| wb_reg | output | 5 | Destination vector register |
| wb_data | output | VLEN | Full destination vector |

## Verification
The bench runs the four element sizes through both addressing forms. The predicates are sparse, so a unit that picks element predicates from consecutive bits instead of strided ones would produce wrong byte enables and wrong zeroed lanes. One case uses a negative immediate, which exposes a missing sign extension through a large positive address. Another uses a register offset with 8-byte elements, which exposes scaling by 16 where the element size should apply. Segment counts below the maximum show whether upper segments are left holding data. The bench also covers these cases:
- A request held without ready, which would reveal a drifting address.
- A nonzero reserved field and a misaligned stack pointer. Here a faulty unit would still emit a request.

// File: rtl/qld_pkg.sv
package qld_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_WB   = 2'd3
    } qld_state_e;

    localparam int QW_BYTES = 16;
    localparam int QW_BITS  = 128;
    localparam logic [4:0] SP_INDEX = 5'd31;

endpackage

// File: rtl/qld_decode.sv
module qld_decode
    import qld_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic [31:0]   insn,
    input  logic          imm_form,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] off_val,
    input  logic [15:0]   pred,
    output logic [4:0]    zt,
    output logic [4:0]    rn,
    output logic [4:0]    rm,
    output logic [2:0]    pg,
    output logic          bad_num,
    output logic          sp_misalign,
    output logic [AW-1:0] ea,
    output logic [15:0]   be
);
    logic [1:0]    esz;
    logic [AW-1:0] imm_sx;

    always_comb begin
        zt          = insn[4:0];
        rn          = insn[9:5];
        pg          = insn[12:10];
        rm          = insn[20:16];
        esz         = insn[24:23];
        bad_num     = (insn[22:21] != 2'b00);
        sp_misalign = (rn == SP_INDEX) && (base_val[3:0] != 4'd0);
        imm_sx      = {{(AW-4){insn[19]}}, insn[19:16]};
        if (imm_form) begin
            ea = base_val + (imm_sx << 4);
        end else begin
            ea = base_val + (off_val << esz);
        end
    end

    for (genvar b = 0; b < QW_BYTES; b++) begin : g_be
        localparam int P1 = b & ~1;
        localparam int P2 = b & ~3;
        localparam int P3 = b & ~7;
        always_comb begin
            case (esz)
                2'd0:    be[b] = pred[b];
                2'd1:    be[b] = pred[P1];
                2'd2:    be[b] = pred[P2];
                default: be[b] = pred[P3];
            endcase
        end
    end

endmodule

// File: rtl/qld_lane_zero.sv
module qld_lane_zero
    import qld_pkg::*;
(
    input  logic [QW_BITS-1:0]  data_in,
    input  logic [QW_BYTES-1:0] keep,
    output logic [QW_BITS-1:0]  data_out
);
    for (genvar b = 0; b < QW_BYTES; b++) begin : g_byte
        assign data_out[b*8 +: 8] = keep[b] ? data_in[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/qld_replicate.sv
module qld_replicate
    import qld_pkg::*;
#(
    parameter int MAX_SEG = 4,
    parameter int SEG_W   = 3
) (
    input  logic [QW_BITS-1:0]         qw,
    input  logic [SEG_W-1:0]           seg_cnt,
    output logic [MAX_SEG*QW_BITS-1:0] vec
);
    for (genvar s = 0; s < MAX_SEG; s++) begin : g_seg
        localparam logic [SEG_W:0] SIDX = (SEG_W+1)'(s);
        assign vec[s*QW_BITS +: QW_BITS] = (SIDX < {1'b0, seg_cnt}) ? qw : '0;
    end
endmodule

// File: rtl/qld_bcast_unit.sv
module qld_bcast_unit
    import qld_pkg::*;
#(
    parameter int AW      = 64,
    parameter int VLEN    = 512,
    parameter int MAX_SEG = VLEN / 128,
    parameter int SEG_W   = $clog2(MAX_SEG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  logic [31:0]       issue_insn,
    input  logic              issue_imm_form,
    output logic [4:0]        base_sel,
    output logic [4:0]        offset_sel,
    output logic [2:0]        pred_sel,
    input  logic [AW-1:0]     base_value,
    input  logic [AW-1:0]     offset_value,
    input  logic [15:0]       pred_value,
    input  logic [SEG_W-1:0]  seg_count,
    output logic              undef_pulse,
    output logic              fault_pulse,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [AW-1:0]     mem_req_addr,
    output logic [15:0]       mem_req_be,
    input  logic              mem_rsp_valid,
    input  logic [127:0]      mem_rsp_data,
    output logic              wb_valid,
    output logic [4:0]        wb_reg,
    output logic [VLEN-1:0]   wb_data
);
    typedef struct packed {
        qld_state_e          st;
        logic [AW-1:0]       addr;
        logic [15:0]         be;
        logic [127:0]        qw;
        logic [4:0]          zt;
        logic [SEG_W-1:0]    seg;
        logic                undef;
        logic                fault;
    } qld_regs_t;

    qld_regs_t r_q, r_d;

    logic [4:0]    dec_zt;
    logic [4:0]    dec_rn;
    logic [4:0]    dec_rm;
    logic [2:0]    dec_pg;
    logic          dec_bad;
    logic          dec_misal;
    logic [AW-1:0] dec_ea;
    logic [15:0]   dec_be;
    logic [127:0]  masked_qw;

    qld_decode #(.AW(AW)) u_dec (
        .insn        (issue_insn),
        .imm_form    (issue_imm_form),
        .base_val    (base_value),
        .off_val     (offset_value),
        .pred        (pred_value),
        .zt          (dec_zt),
        .rn          (dec_rn),
        .rm          (dec_rm),
        .pg          (dec_pg),
        .bad_num     (dec_bad),
        .sp_misalign (dec_misal),
        .ea          (dec_ea),
        .be          (dec_be)
    );

    qld_lane_zero u_zero (
        .data_in  (mem_rsp_data),
        .keep     (r_q.be),
        .data_out (masked_qw)
    );

    qld_replicate #(.MAX_SEG(MAX_SEG), .SEG_W(SEG_W)) u_rep (
        .qw      (r_q.qw),
        .seg_cnt (r_q.seg),
        .vec     (wb_data)
    );

    always_comb begin
        r_d       = r_q;
        r_d.undef = 1'b0;
        r_d.fault = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (issue_valid) begin
                    if (dec_bad) begin
                        r_d.undef = 1'b1;
                    end else if (dec_misal) begin
                        r_d.fault = 1'b1;
                    end else begin
                        r_d.st   = ST_REQ;
                        r_d.addr = dec_ea;
                        r_d.be   = dec_be;
                        r_d.zt   = dec_zt;
                        r_d.seg  = seg_count;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.qw = masked_qw;
                    r_d.st = ST_WB;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign issue_ready   = (r_q.st == ST_IDLE);
    assign base_sel      = dec_rn;
    assign offset_sel    = dec_rm;
    assign pred_sel      = dec_pg;
    assign undef_pulse   = r_q.undef;
    assign fault_pulse   = r_q.fault;
    assign mem_req_valid = (r_q.st == ST_REQ);
    assign mem_req_addr  = r_q.addr;
    assign mem_req_be    = r_q.be;
    assign wb_valid      = (r_q.st == ST_WB);
    assign wb_reg        = r_q.zt;

endmodule

// File: rtl/qld_bcast_checker.sv
module qld_bcast_checker #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          issue_valid,
    input logic          issue_ready,
    input logic [31:0]   issue_insn,
    input logic [AW-1:0] base_value,
    input logic          undef_pulse,
    input logic          fault_pulse,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_req_addr,
    input logic [15:0]   mem_req_be,
    input logic          mem_rsp_valid,
    input logic          wb_valid
);
    AST_UNDEF_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && issue_ready && (issue_insn[22:21] != 2'b00) |=> undef_pulse && !mem_req_valid); // R1

    AST_FAULT_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && issue_ready && (issue_insn[22:21] == 2'b00) && (issue_insn[9:5] == 5'd31)
        && (base_value[3:0] != 4'd0) |=> fault_pulse && !mem_req_valid); // R8

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_be)); // R9

    AST_WB_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(mem_rsp_valid)); // R9

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !issue_ready); // R10

    AST_EXCLUSIVE_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({undef_pulse, fault_pulse, mem_req_valid, wb_valid})); // R10
endmodule

bind qld_bcast_unit qld_bcast_checker #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_valid   (issue_valid),
    .issue_ready   (issue_ready),
    .issue_insn    (issue_insn),
    .base_value    (base_value),
    .undef_pulse   (undef_pulse),
    .fault_pulse   (fault_pulse),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_be    (mem_req_be),
    .mem_rsp_valid (mem_rsp_valid),
    .wb_valid      (wb_valid)
);

// File: tb/qld_bcast_unit_test.sv
module qld_bcast_unit_test;
    localparam int AW   = 64;
    localparam int VLEN = 512;
    localparam int NSEG = VLEN / 128;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              issue_valid = 1'b0;
    logic              issue_ready;
    logic [31:0]       issue_insn = '0;
    logic              issue_imm_form = 1'b0;
    logic [4:0]        base_sel;
    logic [4:0]        offset_sel;
    logic [2:0]        pred_sel;
    logic [AW-1:0]     base_value = '0;
    logic [AW-1:0]     offset_value = '0;
    logic [15:0]       pred_value = '0;
    logic [2:0]        seg_count = 3'd4;
    logic              undef_pulse;
    logic              fault_pulse;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [AW-1:0]     mem_req_addr;
    logic [15:0]       mem_req_be;
    logic              mem_rsp_valid = 1'b0;
    logic [127:0]      mem_rsp_data = '0;
    logic              wb_valid;
    logic [4:0]        wb_reg;
    logic [VLEN-1:0]   wb_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    qld_bcast_unit #(.AW(AW), .VLEN(VLEN)) uut (.*);

    typedef struct packed {
        logic [1:0]  esz;
        logic        immf;
        logic [4:0]  offf;
        logic [63:0] base;
        logic [63:0] off;
        logic [15:0] pred;
        logic [2:0]  seg;
        logic [63:0] exp_addr;
        logic [15:0] exp_be;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'd0, 1'b1, 5'h01, 64'h1000, 64'h0, 16'hFFFF, 3'd4, 64'h1010, 16'hFFFF},
        '{2'd1, 1'b0, 5'h07, 64'h2000, 64'h3, 16'h0005, 3'd1, 64'h2006, 16'h000F},
        '{2'd2, 1'b1, 5'h0E, 64'h3000, 64'h0, 16'h0010, 3'd2, 64'h2FE0, 16'h00F0},
        '{2'd3, 1'b0, 5'h09, 64'h4000, 64'h2, 16'h0100, 3'd3, 64'h4010, 16'hFF00}
    };

    function automatic logic [31:0] mk_insn(logic [1:0] esz, logic [1:0] num, logic [4:0] offf,
                                            logic [2:0] pg, logic [4:0] rn, logic [4:0] zt);
        return {7'b1010010, esz, num, offf, 3'b001, pg, rn, zt};
    endfunction

    function automatic logic [VLEN-1:0] exp_vec(logic [127:0] d, logic [15:0] be, logic [2:0] seg);
        logic [127:0] q;
        logic [VLEN-1:0] v;
        for (int b = 0; b < 16; b++) q[b*8 +: 8] = be[b] ? d[b*8 +: 8] : 8'h00;
        v = '0;
        for (int s = 0; s < NSEG; s++) if (s < int'(seg)) v[s*128 +: 128] = q;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] insn, input logic immf, input logic [63:0] base,
                         input logic [63:0] off, input logic [15:0] pred, input logic [2:0] seg);
        @(negedge clk);
        issue_insn = insn; issue_imm_form = immf; base_value = base;
        offset_value = off; pred_value = pred; seg_count = seg; issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic full_op(input logic [31:0] insn, input logic immf, input logic [63:0] base,
                           input logic [63:0] off, input logic [15:0] pred, input logic [2:0] seg,
                           input logic [63:0] ea, input logic [15:0] be, input int stall,
                           input logic [127:0] data, input string tag);
        issue(insn, immf, base, off, pred, seg);
        chk(mem_req_valid == 1'b1, {tag, " req"}, VLEN'(mem_req_valid), VLEN'(1));
        chk(mem_req_addr == ea, {tag, " addr R3/R4"}, VLEN'(mem_req_addr), VLEN'(ea));
        chk(mem_req_be == be, {tag, " be R5"}, VLEN'(mem_req_be), VLEN'(be));
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk(mem_req_valid && mem_req_addr == ea && mem_req_be == be, {tag, " hold R9"},
                VLEN'(mem_req_addr), VLEN'(ea));
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(!mem_req_valid && !wb_valid, {tag, " wait"}, VLEN'(wb_valid), '0);
        mem_rsp_valid = 1'b1; mem_rsp_data = data;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        chk(wb_valid == 1'b1, {tag, " wb timing R9"}, VLEN'(wb_valid), VLEN'(1));
        chk(wb_reg == insn[4:0], {tag, " dest R2"}, VLEN'(wb_reg), VLEN'(insn[4:0]));
        chk(wb_data == exp_vec(data, be, seg), {tag, " data R6 R7"}, wb_data, exp_vec(data, be, seg));
        @(negedge clk);
        chk(!wb_valid && issue_ready, {tag, " idle R10"}, VLEN'(issue_ready), VLEN'(1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] ins;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(issue_ready && !mem_req_valid && !wb_valid && !undef_pulse && !fault_pulse,
            "R10 reset", VLEN'({issue_ready, mem_req_valid, wb_valid}), VLEN'(3'b100));

        // R2 register index outputs
        issue_insn = mk_insn(2'd1, 2'd0, 5'h15, 3'd6, 5'h0B, 5'h1C);
        #1;
        chk(base_sel == 5'h0B && offset_sel == 5'h15 && pred_sel == 3'd6, "R2 selects",
            VLEN'({base_sel, offset_sel, pred_sel}), VLEN'({5'h0B, 5'h15, 3'd6}));

        foreach (VECS[k]) begin
            ins = mk_insn(VECS[k].esz, 2'd0, VECS[k].offf, 3'd2, 5'd3, 5'(k + 4));
            full_op(ins, VECS[k].immf, VECS[k].base, VECS[k].off, VECS[k].pred, VECS[k].seg,
                    VECS[k].exp_addr, VECS[k].exp_be, k,
                    {32'hA1B2C3D4 + 32'(k), 32'h55667788, 32'h99AABBCC, 32'hDDEEFF00}, "vec");
        end

        // R1: reserved field nonzero
        issue(mk_insn(2'd0, 2'd1, 5'h0, 3'd0, 5'd31, 5'd1), 1'b1, 64'h1003, 64'h0, 16'hFFFF, 3'd4);
        chk(undef_pulse && !fault_pulse && !mem_req_valid, "R1 undefined",
            VLEN'({undef_pulse, fault_pulse, mem_req_valid}), VLEN'(3'b100));
        @(negedge clk);
        chk(!undef_pulse && !mem_req_valid && issue_ready, "R1 no access",
            VLEN'({undef_pulse, mem_req_valid}), '0);

        // R8: misaligned stack pointer
        issue(mk_insn(2'd2, 2'd0, 5'h1, 3'd0, 5'd31, 5'd2), 1'b1, 64'h7008, 64'h0, 16'hFFFF, 3'd4);
        chk(fault_pulse && !undef_pulse && !mem_req_valid, "R8 fault",
            VLEN'({fault_pulse, undef_pulse, mem_req_valid}), VLEN'(3'b100));
        @(negedge clk);
        chk(!fault_pulse && !mem_req_valid, "R8 no access", VLEN'({fault_pulse, mem_req_valid}), '0);

        // R8: misaligned general base register is not checked
        full_op(mk_insn(2'd0, 2'd0, 5'h2, 3'd0, 5'd30, 5'd3), 1'b0, 64'h7008, 64'h5, 16'h00FF, 3'd4,
                64'h700D, 16'h00FF, 0, 128'h0123456789ABCDEF_FEDCBA9876543210, "R8 nonsp");

        // R8: aligned stack pointer proceeds, with immediate -8 (R3)
        full_op(mk_insn(2'd3, 2'd0, 5'h8, 3'd0, 5'd31, 5'd31), 1'b1, 64'h8000, 64'h0, 16'h0001, 3'd4,
                64'h7F80, 16'h00FF, 2, 128'hCAFEBABE_DEADBEEF_0BADF00D_12345678, "R8 sp ok");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule